// File: doc/BRIEF.md
# Pipelined Byte-Enabled Memory Port

This block is a single synchronous access port onto an on-chip word array whose words are two 9-bit bytes wide (18 bits). Every rising clock edge it captures the address, write data, the pair of chip selects, the two active-low byte enables and the read/write strobe. One edge later it either writes the enabled bytes into the array or reads the addressed word. For a read, the word appears on the output one cycle after it was sampled. Each output byte carries a drive flag that stands in for a tri-state buffer. A byte is driven only when it was read, its byte enable was low, the port was armed, and the asynchronous output enable is low.

Deselecting the port puts it to sleep. A small wake-up state machine then tracks re-activation: the first two consecutive selected cycles after a deselect (or after reset) still reach the array, but their reads drive nothing. Only the third consecutive selected access drives the outputs again. The machine has three states:
- `ST_SLEEP`: entered on reset or whenever a deselect is sampled.
- `ST_WAKE`: SLEEP moves here on a selected sample.
- `ST_LIVE`: WAKE moves here on a selected sample. LIVE stays in LIVE while the port stays selected.

Any deselected sample returns the machine from WAKE or LIVE to SLEEP. Reads are armed only while the machine is in LIVE at the sampling edge.

The array depth is 2^ADDR_W words. ADDR_W = 15 gives the 32K-word configuration; the default is kept small. The array contents are undefined at reset.

Top module: `mport_top`

## Requirements
- R1: The port is selected only when `ce0_n_i` = 0 and `ce1_i` = 1. A sample with any other combination performs no write and causes no drive.
- R2: A sampled write (`wr_n_i` = 0) updates only the enabled bytes. Byte 0 is bits 8:0, enabled by `ben_n_i[0]` = 0. Byte 1 is bits 17:9, enabled by `ben_n_i[1]` = 0. A disabled byte keeps its old contents.
- R3: For a read sampled at edge k, the word appears on `rdata_o`, with its drive flags set, after edge k+1 and not earlier.
- R4: A read drives only the bytes whose enable bit was 0. In `drive_o`, bit b belongs to byte b. An undriven byte reads as zero on `rdata_o`.
- R5: In the cycle after a sampled write, no byte is driven.
- R6: While `oe_n_i` = 1, `drive_o` and `rdata_o` are zero at once, with no clock edge. Lowering `oe_n_i` restores the registered drive state immediately.
- R7: A deselect or a disabled byte sampled at edge k stops driving only after edge k+1. The output in any cycle reflects the controls sampled at the previous edge.
- R8: After a deselected sample, reads in the next two selected cycles drive nothing, although writes in those cycles still update the array. The third consecutive selected read drives normally.
- R9: Synchronous active-high `rst` clears all drive flags and puts the port to sleep, so the same two-cycle wake-up as in R8 applies after reset.
- R10: A read sampled in the cycle right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ce0_n_i | input | 1 | Chip select, active low |
| ce1_i | input | 1 | Chip select, active high |
| wr_n_i | input | 1 | 0 = write, 1 = read |
| ben_n_i | input | 2 | Byte enables, active low, bit b for byte b |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 18 | Write data |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | 18 | Read data, zero in undriven bytes |
| drive_o | output | 2 | Per-byte drive flag, 1 = byte driven |

## Verification
The hardest situation to reach is the wake-up window: a deselect must be sampled, then accesses must land in exactly the next two selected cycles, and a write placed inside that window must still reach the array even though its neighbouring reads stay undriven. The stimulus gets there twice. Once straight after reset, with a write followed by two reads of the same word. Once after a deliberate one-cycle deselect in mid-run. In both cases the bench checks that the third selected read drives the value written while the port was waking.

// File: rtl/mport_pkg.sv
`timescale 1ns/1ps
package mport_pkg;
    typedef enum logic [1:0] {
        ST_SLEEP = 2'd0,
        ST_WAKE  = 2'd1,
        ST_LIVE  = 2'd2
    } wake_state_e;
endpackage

// File: rtl/mport_wake_fsm.sv
`timescale 1ns/1ps
module mport_wake_fsm
    import mport_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel_i,
    output logic arm_o
);
    wake_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_SLEEP;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = ST_SLEEP;
        unique case (state_q)
            ST_SLEEP: state_d = sel_i ? ST_WAKE : ST_SLEEP;
            ST_WAKE:  state_d = sel_i ? ST_LIVE : ST_SLEEP;
            ST_LIVE:  state_d = sel_i ? ST_LIVE : ST_SLEEP;
            default:  state_d = ST_SLEEP;
        endcase
    end

    always_comb begin
        arm_o = 1'b0;
        unique case (state_q)
            ST_SLEEP: arm_o = 1'b0;
            ST_WAKE:  arm_o = 1'b0;
            ST_LIVE:  arm_o = 1'b1;
            default:  arm_o = 1'b0;
        endcase
    end

    // R8: WAKE is only ever reached from SLEEP through a selected sample
    assert_wake_entry_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAKE) |-> ($past(state_q) == ST_SLEEP && $past(sel_i)));
endmodule

// File: rtl/mport_array.sv
`timescale 1ns/1ps
module mport_array #(
    parameter int BYTE_W    = 9,
    parameter int NUM_BYTES = 2,
    parameter int ADDR_W    = 10
) (
    input  logic                        clk,
    input  logic                        we_i,
    input  logic                        re_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [BYTE_W*NUM_BYTES-1:0] wdata_i,
    input  logic [NUM_BYTES-1:0]        wmask_i,
    output logic [BYTE_W*NUM_BYTES-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];
        logic [BYTE_W-1:0] lane_rd_q;

        always_ff @(posedge clk) begin
            if (we_i && wmask_i[b])
                lane_mem[addr_i] <= wdata_i[b*BYTE_W +: BYTE_W];
            if (re_i)
                lane_rd_q <= lane_mem[addr_i];
        end

        assign rdata_o[b*BYTE_W +: BYTE_W] = lane_rd_q;
    end
endmodule

// File: rtl/mport_drive.sv
`timescale 1ns/1ps
module mport_drive #(
    parameter int BYTE_W    = 9,
    parameter int NUM_BYTES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load_i,
    input  logic [NUM_BYTES-1:0]        ben_n_i,
    input  logic                        oe_n_i,
    input  logic [BYTE_W*NUM_BYTES-1:0] rdata_i,
    output logic [BYTE_W*NUM_BYTES-1:0] dq_o,
    output logic [NUM_BYTES-1:0]        drive_o
);
    logic [NUM_BYTES-1:0] drv_q;

    always_ff @(posedge clk) begin
        if (rst)         drv_q <= '0;
        else if (load_i) drv_q <= ~ben_n_i;
        else             drv_q <= '0;
    end

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_out
        assign drive_o[b] = drv_q[b] & ~oe_n_i;
        assign dq_o[b*BYTE_W +: BYTE_W] = drive_o[b] ? rdata_i[b*BYTE_W +: BYTE_W] : '0;
    end
endmodule

// File: rtl/mport_top.sv
`timescale 1ns/1ps
module mport_top #(
    parameter int BYTE_W    = 9,
    parameter int NUM_BYTES = 2,
    parameter int ADDR_W    = 10
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ce0_n_i,
    input  logic                        ce1_i,
    input  logic                        wr_n_i,
    input  logic [NUM_BYTES-1:0]        ben_n_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [BYTE_W*NUM_BYTES-1:0] wdata_i,
    input  logic                        oe_n_i,
    output logic [BYTE_W*NUM_BYTES-1:0] rdata_o,
    output logic [NUM_BYTES-1:0]        drive_o
);
    localparam int DATA_W = BYTE_W * NUM_BYTES;

    logic sel;
    logic arm;
    assign sel = ~ce0_n_i & ce1_i;

    // sampled access
    logic                 s1_sel, s1_wr, s1_arm;
    logic [ADDR_W-1:0]    s1_addr;
    logic [DATA_W-1:0]    s1_wdata;
    logic [NUM_BYTES-1:0] s1_ben_n;
    logic [DATA_W-1:0]    arr_rdata;

    mport_wake_fsm u_wake (
        .clk   (clk),
        .rst   (rst),
        .sel_i (sel),
        .arm_o (arm)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_sel   <= 1'b0;
            s1_wr    <= 1'b0;
            s1_arm   <= 1'b0;
            s1_ben_n <= '1;
        end else begin
            s1_sel   <= sel;
            s1_wr    <= ~wr_n_i;
            s1_arm   <= arm & sel;
            s1_ben_n <= ben_n_i;
        end
        s1_addr  <= addr_i;
        s1_wdata <= wdata_i;
    end

    mport_array #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .we_i    (s1_sel & s1_wr),
        .re_i    (s1_sel & ~s1_wr),
        .addr_i  (s1_addr),
        .wdata_i (s1_wdata),
        .wmask_i (~s1_ben_n),
        .rdata_o (arr_rdata)
    );

    mport_drive #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_drive (
        .clk     (clk),
        .rst     (rst),
        .load_i  (s1_sel & ~s1_wr & s1_arm),
        .ben_n_i (s1_ben_n),
        .oe_n_i  (oe_n_i),
        .rdata_i (arr_rdata),
        .dq_o    (rdata_o),
        .drive_o (drive_o)
    );

    // R5: a sampled write leaves every byte undriven in the following cycle
    assert_write_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (s1_sel && s1_wr) |=> (drive_o == '0));

    // R7: a sampled deselect stops driving at the next edge
    assert_deselect_hiz_R7: assert property (@(posedge clk) disable iff (rst)
        (!s1_sel) |=> (drive_o == '0));

    // R8: the two accesses after a deselect are never armed
    assert_wake_gap_R8: assert property (@(posedge clk) disable iff (rst)
        (!sel) |-> ##2 (!s1_arm) ##1 (!s1_arm));

    // R4: an armed read drives exactly its enabled bytes, gated by the output enable
    assert_read_drive_R4: assert property (@(posedge clk) disable iff (rst)
        (s1_sel && !s1_wr && s1_arm) |=>
            (drive_o == (~$past(s1_ben_n) & {NUM_BYTES{!oe_n_i}})));
endmodule

// File: tb/mport_top_tb_top.sv
`timescale 1ns/1ps
module mport_top_tb_top;
    localparam int AW = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce0_n = 1'b1, ce1 = 1'b0, wr_n = 1'b1, oe_n = 1'b0;
    logic [1:0]  ben_n = 2'b11;
    logic [AW-1:0] addr = '0;
    logic [17:0] wdata = '0;
    logic [17:0] rdata;
    logic [1:0]  drive;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mport_top #(.BYTE_W(9), .NUM_BYTES(2), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .ce0_n_i(ce0_n), .ce1_i(ce1), .wr_n_i(wr_n),
        .ben_n_i(ben_n), .addr_i(addr), .wdata_i(wdata), .oe_n_i(oe_n),
        .rdata_o(rdata), .drive_o(drive)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic set_in(input logic c0n, input logic c1, input logic wn,
                          input int a, input logic [17:0] d, input logic [1:0] b);
        ce0_n = c0n; ce1 = c1; wr_n = wn; addr = AW'(a); wdata = d; ben_n = b;
    endtask

    task automatic idle();
        set_in(1'b0, 1'b1, 1'b1, 0, 18'h0, 2'b11);
    endtask

    task automatic check(input string req, input logic [1:0] exp_v,
                         input logic [17:0] exp_d, input bit cmp_data);
        checks++;
        if (drive !== exp_v || (cmp_data && rdata !== exp_d)) begin
            fails++;
            $display("FAIL %s: drive=%b data=%h expected drive=%b data=%h",
                     req, drive, rdata, exp_v, exp_d);
        end
    endtask

    // R9: reset state and wake-up after reset (also R8, R5)
    task automatic t_reset();
        rst = 1'b1; idle(); step(); step();
        check("R9 reset clears drive", 2'b00, 18'h0, 1'b1);
        rst = 1'b0;
        set_in(1'b0, 1'b1, 1'b0, 5, 18'h2A5A5, 2'b00); step();
        set_in(1'b0, 1'b1, 1'b1, 5, 18'h0, 2'b00);     step();
        check("R5 write during wake not driven", 2'b00, 18'h0, 1'b1);
        set_in(1'b0, 1'b1, 1'b1, 5, 18'h0, 2'b00);     step();
        check("R9 second selected read after reset not driven", 2'b00, 18'h0, 1'b1);
        idle(); step();
        check("R8 third selected read drives wake-time write", 2'b11, 18'h2A5A5, 1'b1);
    endtask

    // R2, R3, R10: write then immediate read, byte-masked write
    task automatic t_write_read();
        logic [17:0] first, second, expw;
        first  = 18'h12345;
        second = {9'h1AB, 9'h0FF};
        expw   = {second[17:9], first[8:0]};
        set_in(1'b0, 1'b1, 1'b0, 20, first, 2'b00); step();
        set_in(1'b0, 1'b1, 1'b1, 20, 18'h0, 2'b00); step();
        check("R5 no drive after write", 2'b00, 18'h0, 1'b1);
        idle(); step();
        check("R10 read right after write", 2'b11, first, 1'b1);
        set_in(1'b0, 1'b1, 1'b0, 20, second, 2'b01); step();
        idle(); step();
        set_in(1'b0, 1'b1, 1'b1, 20, 18'h0, 2'b00); step();
        check("R3 no data in the sampling cycle", 2'b00, 18'h0, 1'b1);
        idle(); step();
        check("R2 upper-byte-only write", 2'b11, expw, 1'b1);
    endtask

    // R4: single-byte reads
    task automatic t_bytes();
        logic [17:0] w;
        w = {9'h1AB, 9'h145};
        set_in(1'b0, 1'b1, 1'b1, 20, 18'h0, 2'b10); step();
        set_in(1'b0, 1'b1, 1'b1, 20, 18'h0, 2'b01); step();
        check("R4 lower byte only", 2'b01, {9'h0, w[8:0]}, 1'b1);
        set_in(1'b0, 1'b1, 1'b1, 20, 18'h0, 2'b11); step();
        check("R4 upper byte only", 2'b10, {w[17:9], 9'h0}, 1'b1);
        idle(); step();
        check("R4 no byte enabled", 2'b00, 18'h0, 1'b1);
    endtask

    // R6: asynchronous output enable
    task automatic t_oe();
        set_in(1'b0, 1'b1, 1'b1, 5, 18'h0, 2'b00); step();
        idle(); step();
        oe_n = 1'b1; #1;
        check("R6 oe high floats without clock", 2'b00, 18'h0, 1'b1);
        oe_n = 1'b0; #1;
        check("R6 oe low restores drive", 2'b11, 18'h2A5A5, 1'b1);
    endtask

    // R7, R1: deselect timing and writes while deselected
    task automatic t_deselect();
        set_in(1'b0, 1'b1, 1'b1, 5, 18'h0, 2'b00); step();
        set_in(1'b1, 1'b1, 1'b0, 5, 18'h3FFFF, 2'b00); step();
        check("R7 still driving the edge after deselect sample", 2'b11, 18'h2A5A5, 1'b1);
        set_in(1'b0, 1'b0, 1'b0, 5, 18'h15555, 2'b00); step();
        check("R7 undriven after deselect", 2'b00, 18'h0, 1'b1);
        set_in(1'b1, 1'b0, 1'b0, 5, 18'h0AAAA, 2'b00); step();
        check("R1 deselected cycle not driven", 2'b00, 18'h0, 1'b1);
        idle(); step();
        idle(); step();
        set_in(1'b0, 1'b1, 1'b1, 5, 18'h0, 2'b00); step();
        set_in(1'b0, 1'b1, 1'b1, 5, 18'h0, 2'b11); step();
        check("R1 deselected writes ignored", 2'b11, 18'h2A5A5, 1'b1);
        idle(); step();
        check("R7 byte disable stops drive next edge", 2'b00, 18'h0, 1'b1);
    endtask

    // R8: wake-up after a mid-run deselect
    task automatic t_wake();
        set_in(1'b1, 1'b1, 1'b1, 0, 18'h0, 2'b11); step();
        set_in(1'b0, 1'b1, 1'b0, 7, 18'h1C3C3, 2'b00); step();
        set_in(1'b0, 1'b1, 1'b1, 7, 18'h0, 2'b00); step();
        check("R8 write in first wake cycle not driven", 2'b00, 18'h0, 1'b1);
        set_in(1'b0, 1'b1, 1'b1, 7, 18'h0, 2'b00); step();
        check("R8 read in second wake cycle not driven", 2'b00, 18'h0, 1'b1);
        idle(); step();
        check("R8 third selected read drives", 2'b11, 18'h1C3C3, 1'b1);
    endtask

    initial begin
        fork
            begin
                #(20 * 100000);
                if (!done) begin
                    fails++;
                    $display("FAIL watchdog: run did not finish");
                    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                    $finish;
                end
            end
        join_none
        t_reset();
        t_write_read();
        t_bytes();
        t_oe();
        t_deselect();
        t_wake();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule